// File: doc/BRIEF.md
# Per-Flag Hazard Tracker for a Status Register

This block sits beside the issue stage of an out-of-order core and tracks read-after-write hazards on the condition-flag register one flag at a time. Each function-unit slot keeps a small mask of the flags its instruction will produce. An instruction about to issue presents the flags it consumes, and the block stalls it only if some slot still owes one of those exact flags. A carry-only consumer therefore passes freely while units that will update zero, overflow or negative are still pending.

When an issue is accepted, the block claims the lowest-numbered idle slot and records the instruction's write mask there. A write-back strobe naming a slot releases that slot and drops its mask. The release takes effect on the hazard check and on the free-slot search in the same cycle. Flag bit order in every mask is bit 0 carry, bit 1 zero, bit 2 overflow, bit 3 negative.

Top module: `flag_dep_matrix`

## Requirements
- R1: After reset, every slot is idle (`slot_busy_o` all zero), every pending mask in `pend_o` is zero, and `stall_o` is low for any read mask.
- R2: An accepted issue marks the lowest-numbered idle slot busy and stores `issue_wr_mask_i` as that slot's pending mask. Slot i occupies `pend_o[i*NUM_FLAGS +: NUM_FLAGS]`, and the change is visible after the next rising edge.
- R3: `stall_o` is high exactly when some slot's pending mask, ANDed with `issue_rd_mask_i`, is nonzero. A read of carry only (mask 4'b0001) is not stalled by pending zero, overflow or negative bits (4'b1110).
- R4: A write-back (`wb_valid_i`) to slot `wb_slot_i` clears that slot's busy bit and pending mask at the next rising edge. A write-back to an idle slot leaves all state unchanged.
- R5: A write-back in the same cycle as an issue check is already seen by the check. The released slot's mask does not cause a stall, and that slot counts as idle for slot selection.
- R6: While `stall_o` is high, `issue_ok_o` is low and no slot changes because of the issue.
- R7: When every slot is busy and none is released this cycle, `issue_ok_o` is low and the slot state is unchanged by the issue.
- R8: An accepted issue with an all-zero write mask still occupies a slot until its write-back.
- R9: `issue_ok_o` is high only when `issue_valid_i` is high. When it is high, `issue_slot_o` names the slot being claimed.
- R10: If a write-back and an accepted issue target the same slot in one cycle, the slot ends busy with the new write mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | An instruction requests issue |
| issue_rd_mask_i | input | NUM_FLAGS | Flags the instruction reads |
| issue_wr_mask_i | input | NUM_FLAGS | Flags the instruction writes |
| wb_valid_i | input | 1 | A unit writes back this cycle |
| wb_slot_i | input | SLOT_W | Slot that writes back |
| stall_o | output | 1 | Read mask hits a pending flag write |
| issue_ok_o | output | 1 | Issue accepted this cycle |
| issue_slot_o | output | SLOT_W | Slot claimed by the accepted issue |
| slot_busy_o | output | NUM_SLOTS | Per-slot occupied bits |
| pend_o | output | NUM_SLOTS*NUM_FLAGS | Per-slot pending flag-write masks |

## Verification
The bench builds the block with its defaults of four slots and four flags. At that size every pair of pending mask and read mask (256 combinations) can be swept against a single loaded slot, which covers the per-flag stall rule in full. The same size keeps the slot set small enough that a long pseudo-random run of issues, stalls and write-backs repeatedly fills all slots, releases them, and collides write-back with issue on one slot. Every cycle of that run is compared against an arithmetic model kept in the bench.

// File: rtl/fdm_pkg.sv
package fdm_pkg;
  localparam int FLAG_COUNT = 4;
  localparam int FLAG_CARRY = 0;
  localparam int FLAG_ZERO  = 1;
  localparam int FLAG_OVF   = 2;
  localparam int FLAG_NEG   = 3;
endpackage

// File: rtl/fdm_slot.sv
module fdm_slot #(
  parameter int NUM_FLAGS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_i,
  input  logic                 clear_i,
  input  logic [NUM_FLAGS-1:0] wr_mask_i,
  output logic                 busy_o,
  output logic [NUM_FLAGS-1:0] mask_o,
  output logic                 eff_busy_o,
  output logic [NUM_FLAGS-1:0] eff_mask_o
);
  logic                 busy_q;
  logic [NUM_FLAGS-1:0] mask_q;

  // same-cycle release is visible to the issue check
  assign eff_busy_o = busy_q & ~clear_i;
  assign eff_mask_o = clear_i ? '0 : mask_q;
  assign busy_o     = busy_q;
  assign mask_o     = mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      mask_q <= '0;
    end else if (set_i) begin
      busy_q <= 1'b1;
      mask_q <= wr_mask_i;
    end else if (clear_i) begin
      busy_q <= 1'b0;
      mask_q <= '0;
    end
  end

  a_r2_set_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> (busy_q && mask_q == $past(wr_mask_i)));
  a_r4_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !set_i) |=> (!busy_q && mask_q == '0));
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clear_i) |=> ($stable(busy_q) && $stable(mask_q)));
endmodule

// File: rtl/fdm_hazard.sv
module fdm_hazard #(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_FLAGS = 4
) (
  input  logic [NUM_SLOTS*NUM_FLAGS-1:0] masks_i,
  input  logic [NUM_FLAGS-1:0]           rd_mask_i,
  output logic                           hit_o
);
  logic [NUM_FLAGS-1:0] acc [NUM_SLOTS+1];
  assign acc[0] = '0;
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_or
    assign acc[s+1] = acc[s] | masks_i[s*NUM_FLAGS +: NUM_FLAGS];
  end
  assign hit_o = |(acc[NUM_SLOTS] & rd_mask_i);
endmodule

// File: rtl/fdm_pick.sv
module fdm_pick #(
  parameter int NUM_SLOTS = 4,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic [NUM_SLOTS-1:0] free_i,
  output logic                 any_o,
  output logic [SLOT_W-1:0]    idx_o,
  output logic [NUM_SLOTS-1:0] grant_o
);
  always_comb begin
    any_o   = 1'b0;
    idx_o   = '0;
    grant_o = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (!any_o && free_i[i]) begin
        any_o      = 1'b1;
        idx_o      = SLOT_W'(i);
        grant_o[i] = 1'b1;
      end
    end
  end

  always_comb begin
    a_r2_grant_onehot: assert ($onehot0(grant_o));
    a_r7_grant_needs_free: assert ((grant_o & ~free_i) == '0);
  end
endmodule

// File: rtl/flag_dep_matrix.sv
module flag_dep_matrix #(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_FLAGS = fdm_pkg::FLAG_COUNT,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           issue_valid_i,
  input  logic [NUM_FLAGS-1:0]           issue_rd_mask_i,
  input  logic [NUM_FLAGS-1:0]           issue_wr_mask_i,
  input  logic                           wb_valid_i,
  input  logic [SLOT_W-1:0]              wb_slot_i,
  output logic                           stall_o,
  output logic                           issue_ok_o,
  output logic [SLOT_W-1:0]              issue_slot_o,
  output logic [NUM_SLOTS-1:0]           slot_busy_o,
  output logic [NUM_SLOTS*NUM_FLAGS-1:0] pend_o
);
  logic [NUM_SLOTS-1:0]           clr, set, eff_busy, grant;
  logic [NUM_SLOTS*NUM_FLAGS-1:0] eff_mask;
  logic                           any_free;
  logic [SLOT_W-1:0]              pick_idx;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign clr[s] = wb_valid_i && (wb_slot_i == SLOT_W'(s));
    assign set[s] = issue_ok_o && grant[s];
    fdm_slot #(.NUM_FLAGS(NUM_FLAGS)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_i      (set[s]),
      .clear_i    (clr[s]),
      .wr_mask_i  (issue_wr_mask_i),
      .busy_o     (slot_busy_o[s]),
      .mask_o     (pend_o[s*NUM_FLAGS +: NUM_FLAGS]),
      .eff_busy_o (eff_busy[s]),
      .eff_mask_o (eff_mask[s*NUM_FLAGS +: NUM_FLAGS])
    );
  end

  fdm_hazard #(.NUM_SLOTS(NUM_SLOTS), .NUM_FLAGS(NUM_FLAGS)) u_hazard (
    .masks_i   (eff_mask),
    .rd_mask_i (issue_rd_mask_i),
    .hit_o     (stall_o)
  );

  fdm_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
    .free_i  (~eff_busy),
    .any_o   (any_free),
    .idx_o   (pick_idx),
    .grant_o (grant)
  );

  assign issue_ok_o   = issue_valid_i && !stall_o && any_free;
  assign issue_slot_o = pick_idx;

  a_r6_no_issue_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !issue_ok_o);
  a_r7_no_issue_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&slot_busy_o) && !wb_valid_i) |-> !issue_ok_o);
  a_r9_ok_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_ok_o |-> issue_valid_i);
  a_r3_stall_needs_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (issue_rd_mask_i != '0));
  a_r8_ok_takes_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_ok_o |=> ($countones(slot_busy_o) >= 1));
endmodule

// File: tb/flag_dep_matrix_tb.sv
module flag_dep_matrix_tb;
  localparam int NS = 4;
  localparam int NF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iv = 1'b0, wbv = 1'b0;
  logic [NF-1:0] rm = '0, wm = '0;
  logic [1:0] wbs = '0;
  logic stall, ok;
  logic [1:0] slot;
  logic [NS-1:0] busy;
  logic [NS*NF-1:0] pend;

  int checks = 0, fails = 0;
  logic          m_busy [NS];
  logic [NF-1:0] m_mask [NS];

  always #10 clk = ~clk;

  flag_dep_matrix u_dut (
    .clk_i(clk), .rst_ni(rst_n), .issue_valid_i(iv), .issue_rd_mask_i(rm),
    .issue_wr_mask_i(wm), .wb_valid_i(wbv), .wb_slot_i(wbs), .stall_o(stall),
    .issue_ok_o(ok), .issue_slot_o(slot), .slot_busy_o(busy), .pend_o(pend)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    for (int s = 0; s < NS; s++) begin
      chk(req, $sformatf("busy[%0d]", s), int'(busy[s]), int'(m_busy[s]));
      chk(req, $sformatf("pend[%0d]", s), int'(pend[s*NF +: NF]), int'(m_mask[s]));
    end
  endtask

  // one cycle: drive, check combinational outputs, clock, update model, check state
  task automatic step(input logic v, input logic [NF-1:0] r, input logic [NF-1:0] w,
                      input logic bv, input logic [1:0] bs, input string req);
    logic          e_busy [NS];
    logic [NF-1:0] e_mask [NS];
    logic [NF-1:0] acc;
    logic e_stall, e_ok, found;
    int   e_slot;
    @(negedge clk);
    iv = v; rm = r; wm = w; wbv = bv; wbs = bs;
    #2;
    acc = '0; found = 1'b0; e_slot = 0;
    for (int s = 0; s < NS; s++) begin
      e_busy[s] = m_busy[s] && !(bv && bs == 2'(s));
      e_mask[s] = (bv && bs == 2'(s)) ? '0 : m_mask[s];
      acc |= e_mask[s];
    end
    for (int s = 0; s < NS; s++)
      if (!found && !e_busy[s]) begin found = 1'b1; e_slot = s; end
    e_stall = |(acc & r);
    e_ok = v && !e_stall && found;
    chk({req, "/R3"}, "stall", int'(stall), int'(e_stall));
    chk({req, "/R9"}, "issue_ok", int'(ok), int'(e_ok));
    if (e_ok) chk({req, "/R2"}, "issue_slot", int'(slot), e_slot);
    for (int s = 0; s < NS; s++) begin
      m_busy[s] = e_busy[s];
      m_mask[s] = e_mask[s];
    end
    if (e_ok) begin m_busy[e_slot] = 1'b1; m_mask[e_slot] = w; end
    @(posedge clk);
    #2;
    chk_state(req);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [15:0] lfsr;
    for (int s = 0; s < NS; s++) begin m_busy[s] = 1'b0; m_mask[s] = '0; end
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state and no stall for all-ones read
    rm = '1;
    #1;
    chk("R1", "stall at reset", int'(stall), 0);
    chk_state("R1");
    rst_n = 1'b1;

    // R3: exhaustive pending x read with one loaded slot
    for (int w = 0; w < 16; w++) begin
      step(1, 4'h0, 4'(w), 0, 2'd0, "R2");
      for (int r = 0; r < 16; r++) step(0, 4'(r), 4'h0, 0, 2'd0, "R3");
      step(0, 4'h0, 4'h0, 1, 2'd0, "R4");
    end
    // R3: carry-only read passes while zero/ovf/neg pending
    step(1, 4'h0, 4'b1110, 0, 2'd0, "R3");
    step(1, 4'b0001, 4'b0001, 0, 2'd0, "R3");
    chk("R3", "carry reader took slot1", int'(busy[1]), 1);
    // R6: carry now pending in slot1, carry read stalls and leaves state
    step(1, 4'b0001, 4'b1111, 0, 2'd0, "R6");
    chk("R6", "no slot2 claim", int'(busy[2]), 0);
    // R8: zero write mask fills slots
    step(1, 4'h0, 4'h0, 0, 2'd0, "R8");
    step(1, 4'h0, 4'h0, 0, 2'd0, "R8");
    chk("R8", "all busy", int'(busy), 15);
    // R7: full, issue refused
    step(1, 4'h0, 4'b0100, 0, 2'd0, "R7");
    // R4: write-back to slot3 then idle write-back
    step(0, 4'h0, 4'h0, 1, 2'd3, "R4");
    step(0, 4'h0, 4'h0, 1, 2'd3, "R4");
    // R5/R10: release slot1 (carry) and carry read issues into slot1 same cycle
    step(1, 4'b0001, 4'b1010, 1, 2'd1, "R5");
    chk("R10", "slot1 mask", int'(pend[NF +: NF]), 4'b1010);
    // R10: release slot0 while full-except-3? fill 3 then collide on 0
    step(1, 4'h0, 4'h1, 0, 2'd0, "R10");
    step(1, 4'h0, 4'h8, 1, 2'd0, "R10");
    chk("R10", "slot0 mask", int'(pend[0 +: NF]), 4'h8);
    // R9: valid low never accepts
    step(0, 4'h0, 4'h0, 1, 2'd2, "R9");
    step(0, 4'h0, 4'h3, 0, 2'd0, "R9");

    // pseudo-random sweep against model
    lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], (lfsr[3:2] == 2'b00) ? lfsr[7:4] : 4'h0, lfsr[11:8],
           lfsr[12] | lfsr[1], lfsr[14:13], "SWEEP");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule